// File: doc/BRIEF.md
# Fractional-Baud Serial Transceiver

This block is a full-duplex asynchronous serial transceiver. Its transmit and receive paths run on their own and share only the frame settings and the baud settings. A frame starts with one low start bit. Then come seven or eight data bits, sent least significant bit first or most significant bit first. An optional even or odd parity bit follows, and the frame closes with one or two high stop bits. The line rests high between frames.

The bit period is set by an integer divisor plus an eight-entry stretch pattern. Frame position k counts from 0 at the start bit. Bit k lasts `baud_div + baud_mod[k mod 8]` clock cycles. A system clock that is not a whole multiple of the baud rate can therefore reach the right average rate: 8.7 cycles per bit, for example, is close to divisor 8 with five or six pattern bits set.

Words to send enter through a valid/ready handshake. The transmitter accepts a word only while it is idle, so a sender that keeps `tx_valid` high simply waits. It must hold `tx_data` and the frame settings stable until the cycle of acceptance. There is no back-pressure on the receive side: each received word appears for one cycle with `rx_valid`, together with its error flags. The receiver captures the frame settings when it sees a start edge. The baud settings must stay unchanged while either path is busy, and `baud_div` must be at least 4.

Top module: `uart_frac`

## Requirements
- R1: After reset `txd` is 1, `tx_ready` is 1 and `rx_valid` is 0.
- R2: A transmitted frame is a 0 start bit followed by the data bits. There are 8 of them when `cfg_eight_bits`=1 and 7 (from `tx_data[6:0]`) when it is 0. They go out in ascending bit order when `cfg_msb_first`=0 and in descending order when it is 1.
- R3: `cfg_parity` 2'b01 adds an even parity bit equal to the XOR of the data bits. 2'b10 adds an odd parity bit equal to the inverse of that XOR. 2'b00 and 2'b11 add no parity bit. When present, the parity bit sits right after the data bits.
- R4: The frame ends with one high stop bit, or with two when `cfg_two_stop`=1.
- R5: Frame position k (start bit = 0) holds `txd` for exactly `baud_div + baud_mod[k mod 8]` cycles.
- R6: `tx_ready` is 1 exactly when the transmitter is idle. A word is taken on a clock edge where `tx_valid` and `tx_ready` are both 1. `txd` drops to the start bit after that edge, `tx_ready` stays 0 for the whole frame, and it returns to 1 one cycle after the last stop-bit cycle.
- R7: A frame with the current settings arriving on `rxd` produces a one-cycle `rx_valid` pulse. The word is right-aligned in `rx_data`, with `rx_data[7]`=0 in 7-bit mode.
- R8: After passing through a two-flop synchroniser, a falling edge on `rxd` starts reception. If the line is high again at the middle of the start bit, the start is dropped and no word is reported.
- R9: If any stop bit is sampled low, `rx_frame_err` is 1 with that word. Otherwise it is 0.
- R10: If the sampled parity bit differs from the parity recomputed from the received data, `rx_parity_err` is 1 with that word. It is always 0 when no parity bit is configured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_eight_bits | input | 1 | 1: eight data bits, 0: seven |
| cfg_parity | input | 2 | 00 none, 01 even, 10 odd, 11 none |
| cfg_two_stop | input | 1 | 1: two stop bits |
| cfg_msb_first | input | 1 | 1: most significant data bit first |
| baud_div | input | 16 | Integer cycles per bit (at least 4) |
| baud_mod | input | 8 | Per-position one-cycle stretch pattern |
| tx_data | input | 8 | Word to transmit |
| tx_valid | input | 1 | Word on tx_data is offered |
| tx_ready | output | 1 | Transmitter idle and accepting |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_data | output | 8 | Received word |
| rx_valid | output | 1 | One-cycle pulse: rx_data and flags valid |
| rx_frame_err | output | 1 | Stop bit was low |
| rx_parity_err | output | 1 | Parity mismatch |

## Verification
Every transmit result is due at a fixed cycle counted from the accepting edge. Bit k covers cycles S_k to S_k+L_k-1, where S_k is the sum of the earlier bit lengths. The bench samples `txd` on the falling clock edges of the first, middle and last cycle of each bit, and it samples `tx_ready` in the final cycle of the frame and in the cycle after it. The receive pulse lands about half a bit plus three synchroniser and edge-detect cycles after the last stop bit begins. A falling-edge monitor counts every `rx_valid` pulse, and the bench then allows a bounded window after the frame ends. For a dropped start bit, the bench confirms over several bit times that the pulse count did not move.

// File: rtl/uart_frac_pkg.sv
package uart_frac_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_RSVD = 2'b11
  } parity_e;

  typedef struct packed {
    logic    eight;
    parity_e par;
    logic    two_stop;
    logic    msb_first;
  } fmt_t;

  typedef enum logic {RX_IDLE, RX_RUN} rx_st_e;

  localparam int FRAME_MAX = 12;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  function automatic logic has_parity(input parity_e p);
    return (p == PAR_EVEN) || (p == PAR_ODD);
  endfunction

  function automatic logic data_parity(input logic [7:0] d, input logic eight,
                                       input parity_e p);
    logic x;
    x = eight ? ^d : ^d[6:0];
    return (p == PAR_ODD) ? ~x : x;
  endfunction

endpackage

// File: rtl/uf_bit_timer.sv
module uf_bit_timer #(
  parameter int DIV_W = 16,
  parameter int MOD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             active,
  input  logic [DIV_W-1:0] div_int,
  input  logic [MOD_W-1:0] mod_pat,
  output logic             mid_tick,
  output logic             end_tick
);
  localparam int IDX_W = (MOD_W > 1) ? $clog2(MOD_W) : 1;

  logic [DIV_W:0]   cnt;
  logic [DIV_W:0]   len;
  logic [IDX_W-1:0] idx;

  // current bit length: integer part plus this position's stretch
  assign len      = {1'b0, div_int} + {{DIV_W{1'b0}}, mod_pat[idx]};
  assign end_tick = active && (cnt == len - 1'b1);
  assign mid_tick = active && (cnt == (len >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      idx <= '0;
    end else if (restart) begin
      cnt <= '0;
      idx <= '0;
    end else if (active) begin
      if (end_tick) begin
        cnt <= '0;
        idx <= (idx == IDX_W'(MOD_W - 1)) ? '0 : idx + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_TICKS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    end_tick |-> !mid_tick); // R5

endmodule

// File: rtl/uf_tx.sv
module uf_tx
  import uart_frac_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int MOD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fmt_t             fmt,
  input  logic [DIV_W-1:0] div_int,
  input  logic [MOD_W-1:0] mod_pat,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             txd
);
  logic [FRAME_MAX-1:0] sh;
  logic [FRAME_MAX-1:0] frame;
  logic [CNT_W-1:0]     left;
  logic [CNT_W-1:0]     nbits;
  logic                 busy;
  logic                 accept;
  logic                 mid_unused;
  logic                 bit_end;

  assign tx_ready = !busy;
  assign accept   = tx_valid && tx_ready;
  assign txd      = sh[0];

  // assemble the whole frame at acceptance; unused upper bits rest high
  always_comb begin
    int nd;
    int pos;
    nd       = fmt.eight ? 8 : 7;
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < nd) frame[1+i] = fmt.msb_first ? tx_data[nd-1-i] : tx_data[i];
    end
    pos = 1 + nd;
    if (has_parity(fmt.par)) begin
      frame[pos] = data_parity(tx_data, fmt.eight, fmt.par);
      pos        = pos + 1;
    end
    nbits = CNT_W'(pos + (fmt.two_stop ? 2 : 1));
  end

  uf_bit_timer #(.DIV_W(DIV_W), .MOD_W(MOD_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (accept),
    .active   (busy),
    .div_int  (div_int),
    .mod_pat  (mod_pat),
    .mid_tick (mid_unused),
    .end_tick (bit_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      left <= '0;
      busy <= 1'b0;
    end else if (accept) begin
      sh   <= frame;
      left <= nbits;
      busy <= 1'b1;
    end else if (busy && bit_end) begin
      sh   <= {1'b1, sh[FRAME_MAX-1:1]};
      left <= left - 1'b1;
      if (left == CNT_W'(1)) busy <= 1'b0;
    end
  end

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd); // R2
  AST_READY_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd); // R6
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_end) |=> $stable(txd)); // R5

endmodule

// File: rtl/uf_rx.sv
module uf_rx
  import uart_frac_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int MOD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fmt_t             fmt,
  input  logic [DIV_W-1:0] div_int,
  input  logic [MOD_W-1:0] mod_pat,
  input  logic             rxd,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             rx_frame_err,
  output logic             rx_parity_err
);
  logic       s1, s2, prev;
  rx_st_e     st;
  fmt_t       fmt_q;
  logic [3:0] bitn, nd, nlast, k, didx;
  logic [7:0] data_q;
  logic       perr, ferr, hp;
  logic       fall, start, mid, end_unused;

  assign fall  = prev && !s2;
  assign start = (st == RX_IDLE) && fall;
  assign nd    = fmt_q.eight ? 4'd8 : 4'd7;
  assign hp    = has_parity(fmt_q.par);
  assign nlast = nd + {3'b000, hp} + (fmt_q.two_stop ? 4'd2 : 4'd1);
  assign k     = bitn - 4'd1;
  assign didx  = fmt_q.msb_first ? (nd - 4'd1 - k) : k;

  uf_bit_timer #(.DIV_W(DIV_W), .MOD_W(MOD_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (start),
    .active   (st == RX_RUN),
    .div_int  (div_int),
    .mod_pat  (mod_pat),
    .mid_tick (mid),
    .end_tick (end_unused)
  );

  // two-flop synchroniser plus edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      prev <= 1'b1;
    end else begin
      s1   <= rxd;
      s2   <= s1;
      prev <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= RX_IDLE;
      fmt_q         <= '0;
      bitn          <= '0;
      data_q        <= '0;
      perr          <= 1'b0;
      ferr          <= 1'b0;
      rx_data       <= '0;
      rx_valid      <= 1'b0;
      rx_frame_err  <= 1'b0;
      rx_parity_err <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (start) begin
        st     <= RX_RUN;
        fmt_q  <= fmt;
        bitn   <= '0;
        data_q <= '0;
        perr   <= 1'b0;
        ferr   <= 1'b0;
      end else if (st == RX_RUN && mid) begin
        if (bitn == 4'd0) begin
          if (s2) st <= RX_IDLE;          // start bit gone high: glitch
        end else if (bitn <= nd) begin
          data_q[didx[2:0]] <= s2;
        end else if (hp && bitn == nd + 4'd1) begin
          perr <= (s2 != data_parity(data_q, fmt_q.eight, fmt_q.par));
        end else if (!s2) begin
          ferr <= 1'b1;
        end
        if (!(bitn == 4'd0 && s2)) begin
          bitn <= bitn + 4'd1;
          if (bitn == nlast) begin
            st            <= RX_IDLE;
            rx_valid      <= 1'b1;
            rx_data       <= data_q;
            rx_frame_err  <= ferr || !s2;
            rx_parity_err <= perr;
          end
        end
      end
    end
  end

  AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R7
  AST_RX_7BIT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !fmt_q.eight) |-> !rx_data[7]); // R7
  AST_RX_GLITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_RUN && bitn == 4'd0 && mid && s2) |=> (st == RX_IDLE && !rx_valid)); // R8
  AST_RX_NO_PAR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !hp) |-> !rx_parity_err); // R10

endmodule

// File: rtl/uart_frac.sv
module uart_frac
  import uart_frac_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int MOD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_eight_bits,
  input  logic [1:0]       cfg_parity,
  input  logic             cfg_two_stop,
  input  logic             cfg_msb_first,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [MOD_W-1:0] baud_mod,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             txd,
  input  logic             rxd,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             rx_frame_err,
  output logic             rx_parity_err
);
  fmt_t fmt;

  assign fmt.eight     = cfg_eight_bits;
  assign fmt.par       = parity_e'(cfg_parity);
  assign fmt.two_stop  = cfg_two_stop;
  assign fmt.msb_first = cfg_msb_first;

  uf_tx #(.DIV_W(DIV_W), .MOD_W(MOD_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .fmt      (fmt),
    .div_int  (baud_div),
    .mod_pat  (baud_mod),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .txd      (txd)
  );

  uf_rx #(.DIV_W(DIV_W), .MOD_W(MOD_W)) u_rx (
    .clk           (clk),
    .rst_n         (rst_n),
    .fmt           (fmt),
    .div_int       (baud_div),
    .mod_pat       (baud_mod),
    .rxd           (rxd),
    .rx_data       (rx_data),
    .rx_valid      (rx_valid),
    .rx_frame_err  (rx_frame_err),
    .rx_parity_err (rx_parity_err)
  );

endmodule

// File: tb/uart_frac_tb.sv
module uart_frac_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_eight_bits, cfg_two_stop, cfg_msb_first;
  logic [1:0]  cfg_parity;
  logic [15:0] baud_div;
  logic [7:0]  baud_mod;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_ready, txd, rxd;
  logic [7:0]  rx_data;
  logic        rx_valid, rx_frame_err, rx_parity_err;
  logic        loop_en, rxd_drv;

  int n_chk = 0;
  int n_fail = 0;
  int cap_n = 0;
  logic [7:0] cap_d;
  logic cap_fe, cap_pe;

  always #10 clk = ~clk;
  assign rxd = loop_en ? txd : rxd_drv;

  uart_frac u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_eight_bits(cfg_eight_bits),
    .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
    .cfg_msb_first(cfg_msb_first), .baud_div(baud_div), .baud_mod(baud_mod),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
    .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      cap_n  = cap_n + 1;
      cap_d  = rx_data;
      cap_fe = rx_frame_err;
      cap_pe = rx_parity_err;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [11:0] ref_frame(input logic [7:0] d, input bit e,
      input logic [1:0] p, input bit two, input bit msb, output int n);
    int nd;
    logic par;
    logic [11:0] f;
    nd = e ? 8 : 7;
    f = '1;
    f[0] = 1'b0;
    par = 1'b0;
    for (int i = 0; i < nd; i++) begin
      f[1+i] = msb ? d[nd-1-i] : d[i];
      par = par ^ d[i];
    end
    n = 1 + nd;
    if (p == 2'b01 || p == 2'b10) begin
      f[n] = (p == 2'b10) ? ~par : par;
      n++;
    end
    n = n + (two ? 2 : 1);
    return f;
  endfunction

  function automatic string lab(input int k, input bit e, input logic [1:0] p);
    int nd;
    nd = e ? 8 : 7;
    if (k == 0) return "R2 start bit";
    if (k <= nd) return "R2 data bit";
    if ((p == 2'b01 || p == 2'b10) && k == nd + 1) return "R3 parity bit";
    return "R4 stop bit";
  endfunction

  task automatic set_cfg(input bit e, input logic [1:0] p, input bit two,
                         input bit msb, input logic [15:0] dv, input logic [7:0] md);
    cfg_eight_bits = e;
    cfg_parity     = p;
    cfg_two_stop   = two;
    cfg_msb_first  = msb;
    baud_div       = dv;
    baud_mod       = md;
  endtask

  task automatic wait_rx(input int prev, output bit got);
    got = 0;
    for (int i = 0; i < 40 && !got; i++) begin
      @(negedge clk);
      if (cap_n != prev) got = 1;
    end
  endtask

  task automatic tx_frame(input logic [7:0] d, input bit e, input logic [1:0] p,
      input bit two, input bit msb, input logic [15:0] dv, input logic [7:0] md);
    int n;
    int prev;
    bit got;
    logic [11:0] f;
    logic [7:0] exp_d;
    f = ref_frame(d, e, p, two, msb, n);
    exp_d = e ? d : {1'b0, d[6:0]};
    prev = cap_n;
    @(negedge clk);
    set_cfg(e, p, two, msb, dv, md);
    tx_data  = d;
    tx_valid = 1'b1;
    chk(tx_ready == 1'b1, "R6 ready when idle", tx_ready, 1);
    @(posedge clk);
    for (int k = 0; k < n; k++) begin
      int len;
      len = int'(dv) + int'(md[k%8]);
      for (int j = 0; j < len; j++) begin
        @(negedge clk);
        if (k == 0 && j == 0) begin
          tx_valid = 1'b0;
          chk(tx_ready == 1'b0, "R6 ready low while sending", tx_ready, 0);
        end
        if (j == len / 2) chk(txd == f[k], lab(k, e, p), txd, f[k]);
        if (j == 0 || j == len - 1) chk(txd == f[k], "R5 bit period", txd, f[k]);
      end
    end
    chk(tx_ready == 1'b0, "R5 frame not ended early", tx_ready, 0);
    @(negedge clk);
    chk(tx_ready == 1'b1, "R6 ready after last stop", tx_ready, 1);
    chk(txd == 1'b1, "R4 line idle after frame", txd, 1);
    if (cap_n == prev) wait_rx(prev, got);
    else got = 1;
    chk(got, "R7 word received", got, 1);
    chk(cap_d == exp_d, "R7 received data", cap_d, exp_d);
    chk(cap_fe == 1'b0, "R9 no frame error", cap_fe, 0);
    chk(cap_pe == 1'b0, "R10 no parity error", cap_pe, 0);
  endtask

  task automatic drive_rx(input logic [11:0] f, input int n, input logic [15:0] dv,
                          input logic [7:0] md);
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      int len;
      len = int'(dv) + int'(md[k%8]);
      rxd_drv = f[k];
      repeat (len) @(negedge clk);
    end
    rxd_drv = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    int prev;
    bit got;
    logic [11:0] f;
    rst_n    = 1'b0;
    tx_valid = 1'b0;
    tx_data  = '0;
    loop_en  = 1'b1;
    rxd_drv  = 1'b1;
    set_cfg(1, 2'b00, 0, 0, 16'd8, 8'h00);
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R1 txd idle high", txd, 1);
    chk(tx_ready == 1'b1, "R1 ready after reset", tx_ready, 1);
    chk(rx_valid == 1'b0, "R1 no word after reset", rx_valid, 0);

    // directed formats
    tx_frame(8'hA5, 1, 2'b00, 0, 0, 16'd8, 8'h00);
    tx_frame(8'h3C, 0, 2'b01, 1, 1, 16'd8, 8'b1011_0101);
    tx_frame(8'hC1, 1, 2'b10, 0, 1, 16'd6, 8'b0100_1001);
    tx_frame(8'hFF, 1, 2'b11, 1, 0, 16'd5, 8'hFF);
    tx_frame(8'h00, 0, 2'b10, 0, 0, 16'd4, 8'h00);

    // random frames
    for (int r = 0; r < 12; r++) begin
      tx_frame(8'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
               1'($urandom), 16'($urandom_range(12, 5)), 8'($urandom));
    end

    // receiver-only cases, line driven by the bench
    loop_en = 1'b0;
    set_cfg(1, 2'b01, 0, 0, 16'd8, 8'b0010_0100);
    repeat (20) @(negedge clk);

    prev = cap_n;
    rxd_drv = 1'b0;
    repeat (2) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (60) @(negedge clk);
    chk(cap_n == prev, "R8 glitch start ignored", cap_n, prev);

    f = ref_frame(8'h96, 1, 2'b01, 0, 0, n);
    drive_rx(f, n, 16'd8, 8'b0010_0100);
    wait_rx(prev, got);
    chk(got && cap_d == 8'h96, "R8 frame after glitch", cap_d, 8'h96);
    repeat (10) @(negedge clk);

    prev = cap_n;
    f = ref_frame(8'h5A, 1, 2'b01, 0, 0, n);
    f[n-1] = 1'b0;
    drive_rx(f, n, 16'd8, 8'b0010_0100);
    wait_rx(prev, got);
    chk(got && cap_fe == 1'b1, "R9 low stop bit flagged", cap_fe, 1);
    chk(cap_pe == 1'b0, "R10 parity fine with bad stop", cap_pe, 0);
    chk(cap_d == 8'h5A, "R7 data with bad stop", cap_d, 8'h5A);
    repeat (20) @(negedge clk);

    set_cfg(0, 2'b00, 1, 1, 16'd7, 8'h81);
    prev = cap_n;
    f = ref_frame(8'h2B, 0, 2'b00, 1, 1, n);
    f[n-1] = 1'b0;
    drive_rx(f, n, 16'd7, 8'h81);
    wait_rx(prev, got);
    chk(got && cap_fe == 1'b1, "R9 second stop low flagged", cap_fe, 1);
    chk(cap_d == 8'h2B, "R7 msb-first 7-bit data", cap_d, 8'h2B);
    repeat (20) @(negedge clk);

    set_cfg(1, 2'b01, 0, 0, 16'd8, 8'b0010_0100);
    prev = cap_n;
    f = ref_frame(8'h71, 1, 2'b01, 0, 0, n);
    f[9] = ~f[9];
    drive_rx(f, n, 16'd8, 8'b0010_0100);
    wait_rx(prev, got);
    chk(got && cap_pe == 1'b1, "R10 parity mismatch flagged", cap_pe, 1);
    chk(cap_fe == 1'b0, "R9 no frame error on parity case", cap_fe, 0);
    repeat (20) @(negedge clk);

    set_cfg(1, 2'b10, 0, 0, 16'd9, 8'h00);
    prev = cap_n;
    f = ref_frame(8'h0F, 1, 2'b10, 0, 0, n);
    f[9] = ~f[9];
    drive_rx(f, n, 16'd9, 8'h00);
    wait_rx(prev, got);
    chk(got && cap_pe == 1'b1, "R10 odd parity mismatch flagged", cap_pe, 1);

    finish_run();
  end
endmodule